// File: doc/BRIEF.md
# Descriptor Chain Advance Controller

This block decides how a DMA channel continues once it has finished its current buffer descriptor. Each channel keeps a next-descriptor pointer. The pointer is loaded either by a software start or by the descriptor fetch engine when it reports completion. The block checks that pointer in a fixed order. A pending halt wins first. Next, an all-zero pointer ends the chain quietly. Next, a pointer that is misaligned or out of range halts the channel with a sticky error. Only a pointer that passes all three checks is copied into the current-descriptor register, together with a one-cycle start pulse for the fetch engine.

There are two identical, independent channels. Index 0 is transmit and index 1 is receive. Per-channel signals are packed vectors indexed by channel. A start/done handshake stands in for the descriptor fetch engine.

Each channel runs a five-state machine:
- ST_IDLE: nothing loaded. `start` goes to ST_EVAL.
- ST_EVAL: checks the pointer. A halt or a null pointer goes to ST_STOP. A bad pointer goes to ST_ERR. A valid pointer goes to ST_FETCH.
- ST_FETCH: waits for the fetch engine. `fetch_done` goes to ST_EVAL.
- ST_STOP: the chain has ended cleanly. `start` goes to ST_EVAL.
- ST_ERR: the channel is halted on an error. `err_clr` goes to ST_IDLE.

Top module: `dchain_adv`

## Requirements
- R1: After reset every channel reports status idle, and `nxt_ptr`, `cur_ptr` and `desc_start` are zero. Status codes are 2'b00 idle, 2'b01 busy, 2'b10 stopped and 2'b11 error. `err` is high exactly when the status is error.
- R2: If `halt_req` is high in the evaluation cycle, the channel goes to stopped without error and `cur_ptr` is unchanged, even when the pointer is illegal.
- R3: A next pointer of 0x00000000 with no halt takes the channel to stopped without error, and no descriptor start is issued.
- R4: A pointer whose low 5 bits are non-zero (not 32-byte aligned) takes the channel to error, and `cur_ptr` is left unchanged.
- R5: A pointer with ptr + 32 > `mem_top` takes the channel to error. The test uses a 33-bit sum. A pointer with ptr + 32 == `mem_top` is accepted.
- R6: A valid pointer is copied to `cur_ptr`, `desc_start` pulses for exactly one cycle, and the status becomes busy. All of these are visible in the second clock cycle after the cycle in which `start` is sampled.
- R7: In busy, a `fetch_done` pulse loads `fetch_nxt` into `nxt_ptr`, and that pointer is evaluated on the following cycle under the same rules.
- R8: The error status is sticky. While in error, `start` is ignored, and an `err_clr` pulse returns the channel to idle.
- R9: `start` is honoured only in idle or stopped. In busy it changes neither `nxt_ptr` nor `cur_ptr`.
- R10: The two channels are independent. Activity on one never changes the other's pointers or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_top | input | AW | One past the highest usable byte address |
| start | input | 2 | Per-channel start request |
| start_ptr | input | 2 x AW | First pointer for a start |
| halt_req | input | 2 | Per-channel halt condition |
| fetch_done | input | 2 | Fetch engine finished the current descriptor |
| fetch_nxt | input | 2 x AW | Next pointer from the finished descriptor |
| err_clr | input | 2 | Write-one-to-clear for the error |
| nxt_ptr | output | 2 x AW | Next-descriptor register |
| cur_ptr | output | 2 x AW | Current-descriptor register |
| desc_start | output | 2 | One-cycle pulse to fetch `cur_ptr` |
| status | output | 2 x 2 | Channel status code |
| err | output | 2 | Sticky error flag |

## Verification
The assertions take for granted the following about the inputs:
- `fetch_done` arrives only while the channel is busy.
- `mem_top` is stable while any pointer is being evaluated.
- Control pulses are single-cycle, with `err_clr` never raised together with `start`.

The directed tasks keep to this. They set `mem_top` once after reset, drive every pulse for one clock from the falling edge, and only complete a fetch after observing busy.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_FETCH,
        ST_STOP,
        ST_ERR
    } chan_state_e;

    localparam logic [1:0] STAT_IDLE = 2'b00;
    localparam logic [1:0] STAT_BUSY = 2'b01;
    localparam logic [1:0] STAT_STOP = 2'b10;
    localparam logic [1:0] STAT_ERR  = 2'b11;

endpackage

// File: rtl/dchain_ptr_chk.sv
module dchain_ptr_chk #(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 32
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] mem_top,
    output logic          is_null,
    output logic          misaligned,
    output logic          out_of_range
);
    localparam int LOWB = $clog2(DESC_BYTES);

    logic [AW:0] span_end;

    always_comb begin
        span_end     = {1'b0, ptr} + (AW+1)'(DESC_BYTES);
        is_null      = (ptr == '0);
        misaligned   = (ptr[LOWB-1:0] != '0);
        out_of_range = (span_end > {1'b0, mem_top});
    end
endmodule

// File: rtl/dchain_chan.sv
module dchain_chan
    import dchain_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] mem_top,
    input  logic          start,
    input  logic [AW-1:0] start_ptr,
    input  logic          halt_req,
    input  logic          fetch_done,
    input  logic [AW-1:0] fetch_nxt,
    input  logic          err_clr,
    output logic [AW-1:0] nxt_ptr,
    output logic [AW-1:0] cur_ptr,
    output logic          desc_start,
    output logic [1:0]    status,
    output logic          err
);
    chan_state_e   state_q, state_d;
    logic [AW-1:0] nxt_q, cur_q;
    logic          ds_q;
    logic          p_null, p_mis, p_oor;

    dchain_ptr_chk #(.AW(AW), .DESC_BYTES(DESC_BYTES)) chk_i (
        .ptr          (nxt_q),
        .mem_top      (mem_top),
        .is_null      (p_null),
        .misaligned   (p_mis),
        .out_of_range (p_oor)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_STOP: if (start) state_d = ST_EVAL;
            ST_EVAL: begin
                if (halt_req)            state_d = ST_STOP;
                else if (p_null)         state_d = ST_STOP;
                else if (p_mis || p_oor) state_d = ST_ERR;
                else                     state_d = ST_FETCH;
            end
            ST_FETCH: if (fetch_done) state_d = ST_EVAL;
            ST_ERR:   if (err_clr)    state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_q <= '0;
            cur_q <= '0;
            ds_q  <= 1'b0;
        end else begin
            ds_q <= (state_q == ST_EVAL) && (state_d == ST_FETCH);
            if ((state_q == ST_IDLE || state_q == ST_STOP) && start)
                nxt_q <= start_ptr;
            else if (state_q == ST_FETCH && fetch_done)
                nxt_q <= fetch_nxt;
            if (state_q == ST_EVAL && state_d == ST_FETCH)
                cur_q <= nxt_q;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:          status = STAT_IDLE;
            ST_EVAL, ST_FETCH: status = STAT_BUSY;
            ST_STOP:          status = STAT_STOP;
            ST_ERR:           status = STAT_ERR;
            default:          status = STAT_IDLE;
        endcase
        err        = (state_q == ST_ERR);
        nxt_ptr    = nxt_q;
        cur_ptr    = cur_q;
        desc_start = ds_q;
    end

    AST_HALT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && halt_req) |=> (status == STAT_STOP && $stable(cur_ptr))); // R2
    AST_NULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && !halt_req && p_null) |=> (status == STAT_STOP && !desc_start)); // R3
    AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && !halt_req && p_mis) |=> (err && $stable(cur_ptr))); // R4
    AST_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && !halt_req && !p_null && p_oor) |=> err); // R5
    AST_DS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_start |=> !desc_start); // R6
    AST_CUR_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(desc_start) |-> (cur_ptr == $past(nxt_ptr) && status == STAT_BUSY)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err); // R8
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && !fetch_done) |=> ($stable(nxt_ptr) && $stable(cur_ptr))); // R9
endmodule

// File: rtl/dchain_adv.sv
module dchain_adv #(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        mem_top,
    input  logic [1:0]           start,
    input  logic [1:0][AW-1:0]   start_ptr,
    input  logic [1:0]           halt_req,
    input  logic [1:0]           fetch_done,
    input  logic [1:0][AW-1:0]   fetch_nxt,
    input  logic [1:0]           err_clr,
    output logic [1:0][AW-1:0]   nxt_ptr,
    output logic [1:0][AW-1:0]   cur_ptr,
    output logic [1:0]           desc_start,
    output logic [1:0]           status [2],
    output logic [1:0]           err
);
    localparam int NCH = 2;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dchain_chan #(.AW(AW), .DESC_BYTES(DESC_BYTES)) chan_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .mem_top    (mem_top),
            .start      (start[c]),
            .start_ptr  (start_ptr[c]),
            .halt_req   (halt_req[c]),
            .fetch_done (fetch_done[c]),
            .fetch_nxt  (fetch_nxt[c]),
            .err_clr    (err_clr[c]),
            .nxt_ptr    (nxt_ptr[c]),
            .cur_ptr    (cur_ptr[c]),
            .desc_start (desc_start[c]),
            .status     (status[c]),
            .err        (err[c])
        );
    end
endmodule

// File: tb/dchain_adv_tb.sv
module dchain_adv_tb_top;
    localparam int AW = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [AW-1:0]       mem_top = '0;
    logic [1:0]          start = '0;
    logic [1:0][AW-1:0]  start_ptr = '0;
    logic [1:0]          halt_req = '0;
    logic [1:0]          fetch_done = '0;
    logic [1:0][AW-1:0]  fetch_nxt = '0;
    logic [1:0]          err_clr = '0;
    logic [1:0][AW-1:0]  nxt_ptr, cur_ptr;
    logic [1:0]          desc_start, err;
    logic [1:0]          status [2];

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dchain_adv #(.AW(AW), .DESC_BYTES(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .mem_top(mem_top), .start(start),
        .start_ptr(start_ptr), .halt_req(halt_req), .fetch_done(fetch_done),
        .fetch_nxt(fetch_nxt), .err_clr(err_clr), .nxt_ptr(nxt_ptr),
        .cur_ptr(cur_ptr), .desc_start(desc_start), .status(status), .err(err)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_start(int ch, logic [31:0] p);
        @(negedge clk); start[ch] = 1'b1; start_ptr[ch] = p;
        @(negedge clk); start[ch] = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_fetch(int ch, logic [31:0] p);
        @(negedge clk); fetch_done[ch] = 1'b1; fetch_nxt[ch] = p;
        @(negedge clk); fetch_done[ch] = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_clr(int ch);
        @(negedge clk); err_clr[ch] = 1'b1;
        @(negedge clk); err_clr[ch] = 1'b0;
    endtask

    task automatic t_reset();
        for (int c = 0; c < 2; c++) begin
            chk("R1 status", 32'(status[c]), 32'h0);
            chk("R1 nxt", nxt_ptr[c], 32'h0);
            chk("R1 cur", cur_ptr[c], 32'h0);
            chk("R1 dstart", 32'(desc_start[c]), 32'h0);
            chk("R1 err", 32'(err[c]), 32'h0);
        end
    endtask

    task automatic t_valid_chain();
        do_start(0, 32'h0000_0100);
        chk("R6 cur", cur_ptr[0], 32'h0000_0100);
        chk("R6 dstart", 32'(desc_start[0]), 32'h1);
        chk("R6 busy", 32'(status[0]), 32'h1);
        chk("R10 rx idle", 32'(status[1]), 32'h0);
        chk("R10 rx cur", cur_ptr[1], 32'h0);
        @(negedge clk);
        chk("R6 one cycle", 32'(desc_start[0]), 32'h0);
        do_fetch(0, 32'h0000_0200);
        chk("R7 nxt", nxt_ptr[0], 32'h0000_0200);
        chk("R7 cur", cur_ptr[0], 32'h0000_0200);
        chk("R7 dstart", 32'(desc_start[0]), 32'h1);
    endtask

    task automatic t_busy_ignore();
        @(negedge clk); start[0] = 1'b1; start_ptr[0] = 32'h0000_0400;
        @(negedge clk); start[0] = 1'b0;
        @(negedge clk);
        chk("R9 nxt", nxt_ptr[0], 32'h0000_0200);
        chk("R9 cur", cur_ptr[0], 32'h0000_0200);
        chk("R9 busy", 32'(status[0]), 32'h1);
    endtask

    task automatic t_null();
        do_fetch(0, 32'h0);
        chk("R3 stopped", 32'(status[0]), 32'h2);
        chk("R3 no err", 32'(err[0]), 32'h0);
        chk("R3 no dstart", 32'(desc_start[0]), 32'h0);
        chk("R3 cur kept", cur_ptr[0], 32'h0000_0200);
    endtask

    task automatic t_halt();
        halt_req[0] = 1'b1;
        do_start(0, 32'h0000_0123);
        halt_req[0] = 1'b0;
        chk("R2 stopped", 32'(status[0]), 32'h2);
        chk("R2 no err", 32'(err[0]), 32'h0);
        chk("R2 cur kept", cur_ptr[0], 32'h0000_0200);
    endtask

    task automatic t_misalign();
        do_start(0, 32'h0000_0308);
        chk("R4 error", 32'(status[0]), 32'h3);
        chk("R4 err", 32'(err[0]), 32'h1);
        chk("R4 cur kept", cur_ptr[0], 32'h0000_0200);
        chk("R10 rx untouched", 32'(status[1]), 32'h0);
    endtask

    task automatic t_sticky();
        do_start(0, 32'h0000_0040);
        chk("R8 still err", 32'(status[0]), 32'h3);
        chk("R8 no dstart", 32'(desc_start[0]), 32'h0);
        chk("R8 cur kept", cur_ptr[0], 32'h0000_0200);
        do_clr(0);
        @(negedge clk);
        chk("R8 cleared", 32'(status[0]), 32'h0);
        chk("R8 err low", 32'(err[0]), 32'h0);
        do_start(0, 32'h0000_0040);
        chk("R8 restart", cur_ptr[0], 32'h0000_0040);
    endtask

    task automatic t_range();
        do_start(1, 32'h0000_FFE0);
        chk("R5 edge ok", 32'(status[1]), 32'h1);
        chk("R5 edge cur", cur_ptr[1], 32'h0000_FFE0);
        do_fetch(1, 32'h0001_0000);
        chk("R5 over top", 32'(status[1]), 32'h3);
        chk("R5 cur kept", cur_ptr[1], 32'h0000_FFE0);
        chk("R10 tx busy", 32'(status[0]), 32'h1);
        chk("R10 tx cur", cur_ptr[0], 32'h0000_0040);
        do_clr(1);
        do_start(1, 32'hFFFF_FFE0);
        chk("R5 wrap", 32'(status[1]), 32'h3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mem_top = 32'h0001_0000;
        @(negedge clk);
        t_reset();
        t_valid_chain();
        t_busy_ignore();
        t_null();
        t_halt();
        t_misalign();
        t_sticky();
        t_range();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule